// File: doc/BRIEF.md
# SPI Slave with Selectable Output Timing

This block is a serial-peripheral slave that runs entirely in the system clock domain. The serial clock, chip select and serial data input are brought in through synchronisers. Sampling and driving edges are then found by comparing successive synchronised clock levels. The clock polarity and phase are static inputs. From these the block works out which serial clock edge captures data and which edge may move the output.

Each frame shifts bits MSB first into a `WORD_BITS`-wide register. A frame counts only if chip select rises after exactly `WORD_BITS` sampling edges. In that case the register is copied to a word output and a one-cycle valid pulse is raised. A frame with any other length leaves the word output alone.

After reset the slave is standalone and its serial output is not enabled. A received word with bit 15 set switches on chain forwarding. From then on, during every selected frame, the serial output enable is raised and the output carries the bits that leave the top of the shift register. A static timing select chooses when the output moves. It can move on each driving edge, or `DELAY_CYCLES` system clocks after the shift that a sampling edge causes.

Top module: `spi_shift_slave`

## Requirements
- R1: A sampling edge is a rising serial clock edge when `cfg_cpol` equals `cfg_cpha`, and a falling edge otherwise. The other edge is the driving edge. All four polarity and phase combinations receive words correctly.
- R2: Each sampling edge during a selected frame shifts `sdi` into bit 0 of the shift register, so the word is MSB first. When chip select rises after exactly `WORD_BITS` sampling edges, `rx_word` takes the register value and `rx_valid` is high for exactly one clock.
- R3: A frame with fewer or more than `WORD_BITS` sampling edges raises no `rx_valid`, and `rx_word` keeps its previous value.
- R4: After reset, `rx_word` is 0, `rx_valid` is 0 and `sdo_oe` is 0. `sdo_oe` stays 0 until a word with bit 15 set has been received.
- R5: A received word with bit 15 equal to 1 turns chain forwarding on from the next frame, and it stays on until reset. Received words with bit 15 equal to 0 do not turn it on.
- R6: `sdo_oe` is 1 only while chain forwarding is on and the synchronised chip select is low. It returns to 0 once chip select is high.
- R7: With forwarding on, `sdo` presents the top bit of the shift register. The register keeps its contents between frames, so the bit seen at each sampling edge is the bit shifted in `WORD_BITS` sampling edges earlier.
- R8: With `cfg_late_sdo` = 0, `sdo` moves only at frame start and within three clocks after a driving edge. It keeps its value from a sampling edge until the next driving edge.
- R9: With `cfg_late_sdo` = 1, `sdo` moves `DELAY_CYCLES` clocks after the shift that a sampling edge causes. It does not move on driving edges.
- R10: Serial clock edges while chip select is high shift nothing and count nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level (static) |
| cfg_cpha | input | 1 | Phase select: 0 samples on the first edge, 1 on the second (static) |
| cfg_late_sdo | input | 1 | 0: output moves on the driving edge; 1: output moves a delay after sampling |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data into the slave |
| sdo | output | 1 | Serial data out; meaningful only while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable for the pad; 0 stands for high impedance |
| rx_word | output | WORD_BITS | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |

## Verification
The assertions check on every cycle that `rx_valid` never lasts two clocks and that `rx_word` never changes without it. They also check that the output enable stays low while chip select has been high for several clocks, and that it stays low until a word with bit 15 set has been delivered. The bench scenarios are what show the rest: correct capture in every clock mode, rejection of short and long frames, serial clock edges ignored outside a frame, and the forwarded bit sequence. The bench also tells the two output timings apart by sampling `sdo` between a sampling edge and the following driving edge.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    // Per-cycle events decoded from the synchronised serial lines
    typedef struct packed {
        logic active;   // chip select asserted (synchronised)
        logic start;    // frame begins this cycle
        logic stop;     // frame ends this cycle
        logic sample;   // sampling edge inside a frame
        logic drive;    // driving edge inside a frame
        logic din;      // synchronised serial input
    } spi_evt_t;

    typedef enum logic {
        SDO_ON_DRIVE = 1'b0,
        SDO_AFTER_DELAY = 1'b1
    } sdo_timing_e;

    // Rising edge samples when polarity and phase agree
    function automatic logic sample_on_rise(input logic cpol, input logic cpha);
        return cpol == cpha;
    endfunction

endpackage

// File: rtl/spi_edge_detect.sv
module spi_edge_detect
    import spi_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cpol,
    input  logic     cpha,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     sdi,
    output spi_evt_t evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sclk_q;
    logic [LAST:0] cs_q;
    logic [LAST:0] sdi_q;
    logic          sclk_d;
    logic          cs_d;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_q[g] <= 1'b0;
                    cs_q[g]   <= 1'b1;
                    sdi_q[g]  <= 1'b0;
                end else if (g == 0) begin
                    sclk_q[g] <= sclk;
                    cs_q[g]   <= cs_n;
                    sdi_q[g]  <= sdi;
                end else begin
                    sclk_q[g] <= sclk_q[(g == 0) ? 0 : g - 1];
                    cs_q[g]   <= cs_q[(g == 0) ? 0 : g - 1];
                    sdi_q[g]  <= sdi_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_q[LAST];
            cs_d   <= cs_q[LAST];
        end
    end

    logic rise, fall, on_rise;

    always_comb begin
        rise       = sclk_q[LAST] & ~sclk_d;
        fall       = ~sclk_q[LAST] & sclk_d;
        on_rise    = sample_on_rise(cpol, cpha);
        evt.active = ~cs_q[LAST];
        evt.start  = ~cs_q[LAST] & cs_d;
        evt.stop   = cs_q[LAST] & ~cs_d;
        evt.sample = evt.active & (on_rise ? rise : fall);
        evt.drive  = evt.active & (on_rise ? fall : rise);
        evt.din    = sdi_q[LAST];
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int WORD_BITS = 16,
    parameter int CHAIN_BIT = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 frame_stop,
    input  logic                 sample,
    input  logic                 din,
    output logic                 top_bit,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_valid,
    output logic                 chain_en
);
    localparam int CW = $clog2(WORD_BITS + 2);
    localparam logic [CW-1:0] FULL = CW'(WORD_BITS);
    localparam logic [CW-1:0] OVER = CW'(WORD_BITS + 1);

    logic [WORD_BITS-1:0] shreg;
    logic [CW-1:0]        edges;

    assign top_bit = shreg[WORD_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            edges    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
            chain_en <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (frame_start) begin
                edges <= '0;
            end else if (sample) begin
                shreg <= {shreg[WORD_BITS-2:0], din};
                if (edges != OVER) edges <= edges + 1'b1;
            end
            if (frame_stop && edges == FULL) begin
                rx_word  <= shreg;
                rx_valid <= 1'b1;
                if (shreg[CHAIN_BIT]) chain_en <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_sdo_ctrl.sv
module spi_sdo_ctrl
    import spi_slv_pkg::*;
#(
    parameter int DELAY_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        frame_start,
    input  logic        sample,
    input  logic        drive,
    input  sdo_timing_e timing,
    input  logic        chain_en,
    input  logic        top_bit,
    output logic        sdo,
    output logic        sdo_oe
);
    localparam int DLY = (DELAY_CYCLES < 1) ? 1 : DELAY_CYCLES;
    localparam int DW  = $clog2(DLY + 1);
    localparam logic [DW-1:0] DLY_V = DW'(DLY);
    localparam logic [DW-1:0] ONE   = DW'(1);

    logic          sdo_q;
    logic [DW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q    <= 1'b0;
            wait_cnt <= '0;
        end else if (!active) begin
            wait_cnt <= '0;
        end else if (frame_start) begin
            sdo_q    <= top_bit;
            wait_cnt <= '0;
        end else if (timing == SDO_AFTER_DELAY) begin
            if (sample) begin
                wait_cnt <= DLY_V;
            end else if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
                if (wait_cnt == ONE) sdo_q <= top_bit;
            end
        end else begin
            wait_cnt <= '0;
            if (drive) sdo_q <= top_bit;
        end
    end

    assign sdo    = sdo_q;
    assign sdo_oe = chain_en & active;

endmodule

// File: rtl/spi_shift_slave.sv
module spi_shift_slave
    import spi_slv_pkg::*;
#(
    parameter int WORD_BITS    = 16,
    parameter int CHAIN_BIT    = 15,
    parameter int DELAY_CYCLES = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_cpol,
    input  logic                 cfg_cpha,
    input  logic                 cfg_late_sdo,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 sdi,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_valid
);
    spi_evt_t    evt;
    logic        top_bit;
    logic        chain_en;
    sdo_timing_e timing;

    assign timing = sdo_timing_e'(cfg_late_sdo);

    spi_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .cpol (cfg_cpol),
        .cpha (cfg_cpha),
        .sclk (sclk),
        .cs_n (cs_n),
        .sdi  (sdi),
        .evt  (evt)
    );

    spi_shift_core #(.WORD_BITS(WORD_BITS), .CHAIN_BIT(CHAIN_BIT)) u_core (
        .clk         (clk),
        .rst         (rst),
        .frame_start (evt.start),
        .frame_stop  (evt.stop),
        .sample      (evt.sample),
        .din         (evt.din),
        .top_bit     (top_bit),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid),
        .chain_en    (chain_en)
    );

    spi_sdo_ctrl #(.DELAY_CYCLES(DELAY_CYCLES)) u_sdo (
        .clk         (clk),
        .rst         (rst),
        .active      (evt.active),
        .frame_start (evt.start),
        .sample      (evt.sample),
        .drive       (evt.drive),
        .timing      (timing),
        .chain_en    (chain_en),
        .top_bit     (top_bit),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

endmodule

// File: rtl/spi_shift_slave_chk.sv
module spi_shift_slave_chk #(
    parameter int WORD_BITS = 16,
    parameter int CHAIN_BIT = 15
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic                 sdo_oe,
    input logic [WORD_BITS-1:0] rx_word,
    input logic                 rx_valid
);
    logic cmd_seen;

    always_ff @(posedge clk) begin
        if (rst) cmd_seen <= 1'b0;
        else if (rx_valid && rx_word[CHAIN_BIT]) cmd_seen <= 1'b1;
    end

    // R2: the word strobe is a single-cycle pulse
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R3: the word output only moves together with the strobe
    p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

    // R2: a word is delivered only after chip select has gone high
    p_valid_after_cs_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(cs_n, 2));

    // R4: no output enable before a chain command word has been delivered
    p_standalone_r4: assert property (@(posedge clk) disable iff (rst)
        !cmd_seen |-> !sdo_oe);

    // R6: output enable is released once chip select has been high a while
    p_oe_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

endmodule

bind spi_shift_slave spi_shift_slave_chk #(
    .WORD_BITS(WORD_BITS),
    .CHAIN_BIT(CHAIN_BIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sdo_oe   (sdo_oe),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
);

// File: tb/sim_spi_shift_slave.sv
`timescale 1ns/1ps
module sim_spi_shift_slave;
    localparam int W     = 16;
    localparam int CBIT  = 15;
    localparam int DLY   = 3;
    localparam int H     = 10;   // serial half period in system clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_late_sdo = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe, rx_valid;
    logic [W-1:0] rx_word;

    always #2 clk = ~clk;  // 250 MHz

    spi_shift_slave #(.WORD_BITS(W), .CHAIN_BIT(CBIT), .DELAY_CYCLES(DLY)) u0 (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_late_sdo(cfg_late_sdo), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int vcnt = 0;
    logic [W-1:0] vword = '0;

    // bench model state
    logic [W-1:0] mreg = '0;
    logic [W-1:0] mword = '0;
    bit chain_m = 1'b0;

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            vcnt++;
            vword = rx_word;
        end
    end

    function automatic logic [W-1:0] shift_in(input logic [W-1:0] r, input logic b);
        return {r[W-2:0], b};
    endfunction

    function automatic bit frame_ok(input int n);
        return n == W;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int n, input logic [31:0] data,
                         input bit cpol, input bit cpha, input bit late);
        bit oe_exp;
        int v0;
        logic old_bit;
        oe_exp = chain_m;
        v0 = vcnt;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_late_sdo = late;
        sclk = cpol;
        wait_n(6);
        cs_n = 1'b0;
        wait_n(H);
        for (int i = 0; i < n; i++) begin
            if (cpha) sclk = ~sclk;            // driving edge first
            sdi = data[n-1-i];
            wait_n(H);
            chk("R5,R6 oe in frame", {31'd0, sdo_oe}, {31'd0, oe_exp});
            if (oe_exp) chk("R7 forwarded bit", {31'd0, sdo}, {31'd0, mreg[W-1]});
            old_bit = mreg[W-1];
            mreg = shift_in(mreg, data[n-1-i]);
            sclk = ~sclk;                        // sampling edge
            wait_n(8);
            if (oe_exp) begin
                if (late) chk("R9 late update", {31'd0, sdo}, {31'd0, mreg[W-1]});
                else      chk("R8 held to drive", {31'd0, sdo}, {31'd0, old_bit});
            end
            wait_n(2);
            if (!cpha) sclk = ~sclk;           // driving edge second
        end
        wait_n(H);
        cs_n = 1'b1;
        wait_n(12);
        if (frame_ok(n)) begin
            chk("R2 one strobe", vcnt - v0, 1);
            chk("R1,R2 word", {16'd0, vword}, {16'd0, mreg});
            mword = mreg;
            if (mreg[CBIT]) chain_m = 1'b1;
        end else begin
            chk("R3 no strobe", vcnt - v0, 0);
            chk("R3 word kept", {16'd0, rx_word}, {16'd0, mword});
        end
        chk("R6 oe idle", {31'd0, sdo_oe}, 32'd0);
    endtask

    task automatic idle_toggles(input int k);
        int v0;
        v0 = vcnt;
        for (int i = 0; i < k; i++) begin
            sdi = ~sdi;
            sclk = ~sclk;
            wait_n(H);
        end
        chk("R10 no strobe", vcnt - v0, 0);
        chk("R10 oe idle", {31'd0, sdo_oe}, 32'd0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed);
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        chk("R4 reset word", {16'd0, rx_word}, 32'd0);
        chk("R4 reset valid", {31'd0, rx_valid}, 32'd0);
        chk("R4 reset oe", {31'd0, sdo_oe}, 32'd0);

        // directed: standalone frames in every mode, bit 15 clear
        frame(W, 32'h1234, 0, 0, 0);
        frame(W, 32'h4c3a, 0, 1, 0);
        frame(W, 32'h7001, 1, 0, 1);
        frame(W, 32'h2ffe, 1, 1, 1);
        // wrong lengths
        frame(W - 1, 32'h7fff, 0, 0, 0);
        frame(W + 1, 32'h1ffff, 1, 1, 0);
        frame(1, 32'h1, 0, 1, 0);
        // clock edges with chip select high (R10)
        idle_toggles(6);
        sclk = 1'b0;
        frame(W, 32'h0f0f, 0, 0, 0);
        // chain command (R5)
        frame(W, 32'h8000 | 32'h00a5, 1, 1, 0);
        chk("R5 chain model on", {31'd0, chain_m}, 32'd1);
        // directed chain frames, both timings, all modes
        frame(W, 32'h5a5a, 0, 0, 0);
        frame(W, 32'ha5a5, 0, 0, 1);
        frame(W, 32'h3c3c, 0, 1, 1);
        frame(W, 32'hc3c3, 1, 0, 0);
        frame(W, 32'h0000, 1, 1, 1);
        frame(W - 1, 32'h6b2d, 0, 0, 1);
        idle_toggles(4);
        sclk = 1'b0;
        // constrained random
        for (int r = 0; r < 40; r++) begin
            int unsigned pick;
            int n;
            pick = $urandom % 8;
            n = (pick == 0) ? W - 1 : (pick == 1) ? W + 1 : W;
            frame(n, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule